// File: doc/BRIEF.md
# Subpixel Frame-Dither Scan Controller

This block turns one stored 4-bit colour code into the on/off drive of the red and the green subpixel for the internal scan frame that is being painted. Each subpixel carries a 2-bit intensity level. A three-frame temporal dither cycle produces four visible intensities per subpixel: dark, one-third, two-thirds and full. The two subpixels are modulated independently, so 16 colour codes can be shown.

The block also picks the divisor that sets the internal scan frame rate. Two luminance-select inputs choose among a fast, a middle and a slow rate. A registered over-temperature flag forces the slow rate with hysteresis. The flag is set by a high-threshold comparator and cleared by a low-threshold comparator.

The scan timing runs independently of any incoming video timing. A single-cycle scan-tick strobe marks the end of each completed internal scan frame and advances the dither phase.

Top module: `subpixel_dither_scan`

## Requirements
- R1: A subpixel whose level is 00 is never driven, in any dither phase.
- R2: A subpixel whose level is 01 is driven only in dither phase 0 and is off in phases 1 and 2, which gives one frame in three.
- R3: A subpixel whose level is 10 is driven in dither phases 0 and 1 and is off in phase 2, which gives two frames in three.
- R4: A subpixel whose level is 11 is driven in every dither phase.
- R5: The red level is pixelCode[3:2] and the green level is pixelCode[1:0], most significant bit first. Each drive output depends only on its own level and the phase.
- R6: The dither phase is 0 after reset. It advances by one (0, 1, 2, 0, ...) at each clock edge where scanTick is high and holds otherwise. The drive outputs follow the new phase in the cycle after that edge.
- R7: With the override clear, rateDiv is selected by {lumSel1, lumSel0}: 00 gives DIV_FAST, 01 gives DIV_MID, 10 gives DIV_SLOW, and 11 gives DIV_FAST. The output follows these inputs within the same cycle.
- R8: tempHigh high at a clock edge sets the thermal override from that edge on. While the override is set, rateDiv equals DIV_SLOW whatever the luminance selects are.
- R9: tempLow high with tempHigh low at a clock edge clears the override. tempHigh wins when both are high. With neither high, the override holds, including while the luminance inputs change.
- R10: The override never blanks or alters the subpixel drive. The drive outputs are the same with the override set as with it clear.
- R11: Reset clears the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanTick | input | 1 | One-cycle strobe at the end of each internal scan frame |
| pixelCode | input | 4 | Colour code {red level, green level} |
| lumSel0 | input | 1 | Luminance select, low bit |
| lumSel1 | input | 1 | Luminance select, high bit |
| tempHigh | input | 1 | Comparator flag: board above high threshold |
| tempLow | input | 1 | Comparator flag: board below low threshold |
| redDrive | output | 1 | Red subpixel on for this scan frame |
| greenDrive | output | 1 | Green subpixel on for this scan frame |
| rateDiv | output | DIV_W | Scan-rate clock divisor |

## Verification
The bench builds the block with DIV_W = 8 and the small, pairwise distinct divisors 5, 7 and 11. Any wrong table entry or wrong select decode therefore shows up as a different value at rateDiv. With the 2-bit level fixed, the dither cycle is three frames long, so every level meets every phase within a few scan ticks. Random runs cover all 16 codes in all phases, with and without the override, and overlapping comparator flags.

// File: rtl/dither_scan_pkg.sv
package dither_scan_pkg;

  // Bits per subpixel intensity level.
  parameter int LEVEL_W = 2;
  // Dither cycle length: one frame per nonzero level step.
  localparam int PHASES  = (1 << LEVEL_W) - 1;
  localparam int PHASE_W = (PHASES > 1) ? $clog2(PHASES) : 1;
  // Subpixel channels per pixel: red, green.
  localparam int NUM_CH  = 2;
  localparam int CODE_W  = NUM_CH * LEVEL_W;

  typedef enum logic [1:0] {
    LUM_FAST = 2'b00,
    LUM_MID  = 2'b01,
    LUM_SLOW = 2'b10,
    LUM_TEST = 2'b11
  } lumSetting_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic [PHASE_W-1:0] phase;
    logic               forceSlow;
  } ctrlStrobes_t;

endpackage

// File: rtl/dither_ctrl.sv
module dither_ctrl
  import dither_scan_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         scanTick,
  input  logic         tempHigh,
  input  logic         tempLow,
  output ctrlStrobes_t ctrlBus
);

  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(PHASES - 1);

  logic [PHASE_W-1:0] phaseQ;
  logic               hotQ;

  // Dither phase counter, advanced once per completed scan frame.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= '0;
    end else if (scanTick) begin
      if (phaseQ == LAST_PHASE) phaseQ <= '0;
      else                      phaseQ <= phaseQ + 1'b1;
    end
  end

  // Thermal override flag with hysteresis: set has priority over clear.
  always_ff @(posedge clk) begin
    if (!rstN)          hotQ <= 1'b0;
    else if (tempHigh)  hotQ <= 1'b1;
    else if (tempLow)   hotQ <= 1'b0;
  end

  always_comb begin
    ctrlBus.phase     = phaseQ;
    ctrlBus.forceSlow = hotQ;
  end

endmodule

// File: rtl/dither_datapath.sv
module dither_datapath
  import dither_scan_pkg::*;
#(
  parameter int              DIV_W    = 20,
  parameter logic [DIV_W-1:0] DIV_FAST = DIV_W'(30769),
  parameter logic [DIV_W-1:0] DIV_MID  = DIV_W'(41667),
  parameter logic [DIV_W-1:0] DIV_SLOW = DIV_W'(55556)
) (
  input  ctrlStrobes_t      ctrlBus,
  input  logic [CODE_W-1:0] pixelCode,
  input  logic              lumSel0,
  input  logic              lumSel1,
  output logic [NUM_CH-1:0] driveVec,
  output logic [DIV_W-1:0]  rateDiv
);

  localparam int TABLE_N = 4;

  // Per-channel dither decode: a level of L is on in the first L phases.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    logic [LEVEL_W-1:0] level;
    always_comb begin
      level        = pixelCode[ch*LEVEL_W +: LEVEL_W];
      driveVec[ch] = (32'(level) > 32'(ctrlBus.phase));
    end
  end

  // Divisor table keyed by effective luminance setting.
  logic [DIV_W-1:0] rateTable [TABLE_N];
  for (genvar idx = 0; idx < TABLE_N; idx++) begin : gTable
    localparam lumSetting_t SET = lumSetting_t'(idx);
    if (SET == LUM_MID) begin : gMid
      assign rateTable[idx] = DIV_MID;
    end else if (SET == LUM_SLOW) begin : gSlow
      assign rateTable[idx] = DIV_SLOW;
    end else begin : gFast
      assign rateTable[idx] = DIV_FAST;
    end
  end

  lumSetting_t effSetting;
  always_comb begin
    if (ctrlBus.forceSlow) effSetting = LUM_SLOW;
    else                   effSetting = lumSetting_t'({lumSel1, lumSel0});
    rateDiv = rateTable[effSetting];
  end

endmodule

// File: rtl/subpixel_dither_scan.sv
module subpixel_dither_scan
  import dither_scan_pkg::*;
#(
  parameter int              DIV_W    = 20,
  parameter logic [DIV_W-1:0] DIV_FAST = DIV_W'(30769),
  parameter logic [DIV_W-1:0] DIV_MID  = DIV_W'(41667),
  parameter logic [DIV_W-1:0] DIV_SLOW = DIV_W'(55556)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scanTick,
  input  logic [CODE_W-1:0] pixelCode,
  input  logic              lumSel0,
  input  logic              lumSel1,
  input  logic              tempHigh,
  input  logic              tempLow,
  output logic              redDrive,
  output logic              greenDrive,
  output logic [DIV_W-1:0]  rateDiv
);

  ctrlStrobes_t      ctrlBus;
  logic [NUM_CH-1:0] driveVec;

  dither_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .scanTick (scanTick),
    .tempHigh (tempHigh),
    .tempLow  (tempLow),
    .ctrlBus  (ctrlBus)
  );

  dither_datapath #(
    .DIV_W    (DIV_W),
    .DIV_FAST (DIV_FAST),
    .DIV_MID  (DIV_MID),
    .DIV_SLOW (DIV_SLOW)
  ) uData (
    .ctrlBus   (ctrlBus),
    .pixelCode (pixelCode),
    .lumSel0   (lumSel0),
    .lumSel1   (lumSel1),
    .driveVec  (driveVec),
    .rateDiv   (rateDiv)
  );

  // Channel 1 (upper bits) is red, channel 0 is green.
  assign redDrive   = driveVec[1];
  assign greenDrive = driveVec[0];

endmodule

// File: rtl/dither_scan_checker.sv
module dither_scan_checker
  import dither_scan_pkg::*;
#(
  parameter int              DIV_W    = 20,
  parameter logic [DIV_W-1:0] DIV_SLOW = DIV_W'(55556)
) (
  input logic              clk,
  input logic              rstN,
  input logic              scanTick,
  input logic [CODE_W-1:0] pixelCode,
  input logic              tempHigh,
  input logic              tempLow,
  input logic              redDrive,
  input logic              greenDrive,
  input logic [DIV_W-1:0]  rateDiv,
  input ctrlStrobes_t      ctrlBus
);

  // R1
  a_r1_dark_red: assert property (@(posedge clk) disable iff (!rstN)
    (pixelCode[3:2] == 2'b00) |-> !redDrive);
  // R4
  a_r4_full_green: assert property (@(posedge clk) disable iff (!rstN)
    (pixelCode[1:0] == 2'b11) |-> greenDrive);
  // R2
  a_r2_third_phase0: assert property (@(posedge clk) disable iff (!rstN)
    (pixelCode[3:2] == 2'b01 && redDrive) |-> (ctrlBus.phase == '0));
  // R3
  a_r3_twothird_off_last: assert property (@(posedge clk) disable iff (!rstN)
    (pixelCode[1:0] == 2'b10 && ctrlBus.phase == PHASE_W'(2)) |-> !greenDrive);
  // R6
  a_r6_phase_hold: assert property (@(posedge clk) disable iff (!rstN)
    !scanTick |=> $stable(ctrlBus.phase));
  a_r6_phase_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (scanTick && ctrlBus.phase == PHASE_W'(PHASES - 1)) |=> (ctrlBus.phase == '0));
  // R8
  a_r8_hot_set: assert property (@(posedge clk) disable iff (!rstN)
    tempHigh |=> ctrlBus.forceSlow);
  a_r8_hot_rate: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBus.forceSlow |-> (rateDiv == DIV_SLOW));
  // R9
  a_r9_hot_clear: assert property (@(posedge clk) disable iff (!rstN)
    (tempLow && !tempHigh) |=> !ctrlBus.forceSlow);

endmodule

bind subpixel_dither_scan dither_scan_checker #(
  .DIV_W    (DIV_W),
  .DIV_SLOW (DIV_SLOW)
) uChecker (
  .clk        (clk),
  .rstN       (rstN),
  .scanTick   (scanTick),
  .pixelCode  (pixelCode),
  .tempHigh   (tempHigh),
  .tempLow    (tempLow),
  .redDrive   (redDrive),
  .greenDrive (greenDrive),
  .rateDiv    (rateDiv),
  .ctrlBus    (ctrlBus)
);

// File: tb/tb_subpixel_dither_scan.sv
`timescale 1ns/1ps
module tb_subpixel_dither_scan;

  localparam int DIV_W = 8;
  localparam logic [DIV_W-1:0] D_FAST = 8'd5;
  localparam logic [DIV_W-1:0] D_MID  = 8'd7;
  localparam logic [DIV_W-1:0] D_SLOW = 8'd11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scanTick = 1'b0;
  logic [3:0] pixelCode = 4'h0;
  logic lumSel0 = 1'b0, lumSel1 = 1'b0;
  logic tempHigh = 1'b0, tempLow = 1'b0;
  logic redDrive, greenDrive;
  logic [DIV_W-1:0] rateDiv;

  int checks = 0;
  int errors = 0;
  int expPhase = 0;
  bit expHot = 0;

  always #5 clk = ~clk;

  subpixel_dither_scan #(
    .DIV_W(DIV_W), .DIV_FAST(D_FAST), .DIV_MID(D_MID), .DIV_SLOW(D_SLOW)
  ) dut (
    .clk(clk), .rstN(rstN), .scanTick(scanTick), .pixelCode(pixelCode),
    .lumSel0(lumSel0), .lumSel1(lumSel1), .tempHigh(tempHigh), .tempLow(tempLow),
    .redDrive(redDrive), .greenDrive(greenDrive), .rateDiv(rateDiv)
  );

  function automatic bit expDrive(input logic [1:0] lvl, input int ph);
    case (lvl)
      2'b00: return 1'b0;
      2'b01: return ph == 0;
      2'b10: return ph != 2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] expRate(input bit l1, input bit l0, input bit hot);
    if (hot) return D_SLOW;
    case ({l1, l0})
      2'b01: return D_MID;
      2'b10: return D_SLOW;
      default: return D_FAST;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Advance one clock with the current inputs; update the model.
  task automatic step();
    @(posedge clk);
    if (!rstN) begin
      expPhase = 0; expHot = 0;
    end else begin
      if (scanTick) expPhase = (expPhase + 1) % 3;
      if (tempHigh) expHot = 1;
      else if (tempLow) expHot = 0;
    end
    @(negedge clk);
  endtask

  task automatic checkAll(input string tag);
    #1;
    check({tag, " red"},   redDrive,   expDrive(pixelCode[3:2], expPhase));
    check({tag, " green"}, greenDrive, expDrive(pixelCode[1:0], expPhase));
    check({tag, " rate"},  rateDiv,    expRate(lumSel1, lumSel0, expHot));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    step(); step();
    rstN = 1'b1;
    // R11 reset state: override clear, phase 0
    pixelCode = 4'b0110; // red 01, green 10
    checkAll("R11 reset");
    check("R6 reset phase red", redDrive, 1);

    // R2 R3 R6: walk phases with red 01, green 10
    for (int k = 0; k < 6; k++) begin
      scanTick = 1'b1; step(); scanTick = 1'b0;
      checkAll("R6 walk");
      check("R2 red third", redDrive, (expPhase == 0));
      check("R3 green twothird", greenDrive, (expPhase != 2));
    end
    // R6 hold without tick
    for (int k = 0; k < 3; k++) begin step(); checkAll("R6 hold"); end

    // R1 R4 R5: code red 00 green 11 and reverse, all phases
    for (int k = 0; k < 3; k++) begin
      pixelCode = 4'b0011; #1;
      check("R1 red dark", redDrive, 0);
      check("R4 green full", greenDrive, 1);
      pixelCode = 4'b1100; #1;
      check("R4 red full", redDrive, 1);
      check("R5 green dark", greenDrive, 0);
      scanTick = 1'b1; step(); scanTick = 1'b0;
    end

    // R7 luminance table
    for (int s = 0; s < 4; s++) begin
      {lumSel1, lumSel0} = s[1:0]; #1;
      check("R7 lum table", rateDiv, expRate(s[1], s[0], 0));
    end

    // R8 set override; R10 drive unchanged
    {lumSel1, lumSel0} = 2'b00; pixelCode = 4'b0110;
    tempHigh = 1'b1; step(); tempHigh = 1'b0;
    check("R8 forced slow", rateDiv, D_SLOW);
    check("R10 red under override", redDrive, expDrive(2'b01, expPhase));
    check("R10 green under override", greenDrive, expDrive(2'b10, expPhase));
    // R9 hold while lum changes
    for (int s = 0; s < 4; s++) begin
      {lumSel1, lumSel0} = s[1:0]; step();
      check("R9 hold hot", rateDiv, D_SLOW);
    end
    // R9 both high: set wins
    tempHigh = 1'b1; tempLow = 1'b1; step();
    check("R9 set priority", rateDiv, D_SLOW);
    // R9 clear
    tempHigh = 1'b0; step(); tempLow = 1'b0;
    {lumSel1, lumSel0} = 2'b01; #1;
    check("R9 cleared", rateDiv, D_MID);
    // R11 reset clears override
    tempHigh = 1'b1; step(); tempHigh = 1'b0;
    rstN = 1'b0; step(); rstN = 1'b1;
    checkAll("R11 reset clears");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      pixelCode = 4'($urandom);
      {lumSel1, lumSel0} = 2'($urandom);
      scanTick = ($urandom % 3) == 0;
      tempHigh = ($urandom % 40) == 0;
      tempLow  = ($urandom % 30) == 0;
      checkAll("R5 random");
      step();
    end
    scanTick = 1'b0; tempHigh = 1'b0; tempLow = 1'b0;
    checkAll("R7 final");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule